// File: doc/BRIEF.md
# I2C Target Byte Engine with Host-Controlled Reject

This block is the bit and byte layer of an I2C target with a fixed 7-bit address. It watches SCL and SDA, which reach it already synchronised to the system clock. It recognises START, repeated START and STOP, and compares the first byte after each START with the address the host supplies. It then shifts data bytes in or out, depending on the direction bit of that address byte. The only thing it does to the bus is pull SDA low through an open-drain enable output.

The host side works like a small register file. The host provides:

- an enable level;
- a one-cycle request that makes the next received byte be refused;
- the target's own address;
- a received-byte port with a full flag;
- a transmit-byte port with an empty flag;
- an address-hit flag and a busy flag.

A write of a register pointer followed by a repeated START and a read is supported. Each address phase raises the hit flag again.

A host asks for a reject when the byte that arrives should be refused. For example, a pointer to a register that does not exist can be refused with a NACK. The request clears itself when the refusal goes out. It also clears on STOP, on a fresh address match, and while the block is disabled.

Top module: `i2ct_target`

## Requirements
- R1: With no reject pending, the target pulls SDA low during the ninth SCL clock after every data byte it receives in write direction.
- R2: With a reject pending when a received byte completes, SDA is left released in the ninth clock of that byte, so the controller sees a NACK. The byte still appears on `rx_byte`.
- R3: `nack_pend` becomes 1 only through a `nack_set` pulse while `en` is 1. It returns to 0 at the end of the ninth clock in which the NACK was given, so the next byte is acknowledged again.
- R4: `nack_pend` is cleared by a STOP, by an address match, and in the cycle after `en` is seen low.
- R5: The address byte carries the address in bits 7:1 and the direction in bit 0 (1 = read). On a match the address byte is acknowledged, `addr_hit` is set and `read_dir` takes bit 0. A repeated START followed by a matching address sets `addr_hit` again. `addr_clr` clears `addr_hit`.
- R6: `busy` rises on START. It stays 1 through a repeated START and falls only on STOP or when the block is disabled.
- R7: After reset, and one cycle after `en` is low, the engine is idle. In that state `busy`, `addr_hit`, `rx_full`, `tx_empty`, `nack_pend` and `sda_drive_low` are all 0, even when `en` drops while the target was pulling SDA.
- R8: `sda_drive_low` changes only while SCL is low. START is SDA falling with SCL high; STOP is SDA rising with SCL high.
- R9: A non-matching address byte is not acknowledged. Until the next START or STOP, later bytes are neither acknowledged nor reported.
- R10: In read direction, bytes go out MSB first. When a byte is moved from the transmit buffer into the shifter, `tx_empty` is set; this happens at the end of the address ACK clock and at the end of each ninth clock the controller acknowledged. A `tx_wr` pulse loads the buffer and clears `tx_empty`. If no byte was loaded, 0xFF is sent.
- R11: A NACK from the controller after a transmitted byte ends transmission. SDA stays released and no further byte is taken from the buffer until START or STOP.
- R12: Received bytes arrive MSB first. `rx_byte` holds the last one, and `rx_full` is set after its eighth bit and cleared by an `rx_rd` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable; 0 forces idle and clears flags |
| own_addr | input | 7 | Target address to match |
| nack_set | input | 1 | One-cycle pulse: refuse the next received byte |
| addr_clr | input | 1 | One-cycle pulse: clear `addr_hit` |
| rx_rd | input | 1 | One-cycle pulse: clear `rx_full` |
| tx_wr | input | 1 | One-cycle pulse: load `tx_byte` into the transmit buffer |
| tx_byte | input | 8 | Byte to send in read direction |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open drain) |
| rx_byte | output | 8 | Last received data byte |
| addr_hit | output | 1 | Address matched since last clear |
| rx_full | output | 1 | Unread received byte |
| tx_empty | output | 1 | Transmit buffer consumed, awaiting a new byte |
| busy | output | 1 | Bus transaction in progress (START seen, no STOP yet) |
| nack_pend | output | 1 | Reject request pending |
| read_dir | output | 1 | Direction of the last matched address (1 = read) |

## Verification
Every one of the 128 address values is presented in turn. Exactly one is acknowledged, and for every other value the data byte that follows must stay unacknowledged and unreported, which separates address matching from the skip behaviour. A spread of data values in write direction checks bit order and the acknowledge, with a reject request placed on one byte to show that the refusal lasts one byte and is cleared by STOP, by an address match and by disabling. A register-pointer write with a repeated START into a read streams several preloaded values and then an unloaded byte, which must read as 0xFF. After a controller NACK a zero byte is left in the buffer, and it must not appear on the bus. A disable while the target is pulling the address ACK shows that SDA is released at once.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_SKIP
    } eng_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic logic addr_is_ours(byte_t b, addr_t own);
        return b[BYTE_W-1:1] == own;
    endfunction

    function automatic bitcnt_t full_count();
        return CNT_W'(BYTE_W);
    endfunction

endpackage

// File: rtl/i2ct_line_events.sv
module i2ct_line_events
    import i2ct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl   = scl_i;
        ev.sda   = sda_i;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
    end

endmodule

// File: rtl/i2ct_nack_req.sv
module i2ct_nack_req (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic host_set,
    input  logic bus_stop,
    input  logic addr_match,
    input  logic nack_done,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (!en || bus_stop || addr_match || nack_done) begin
            pend <= 1'b0;
        end else if (host_set) begin
            pend <= 1'b1;
        end
    end

    // R4: the automatic clear conditions always win
    a_r4_nack_autoclear: assert property (@(posedge clk) disable iff (rst)
        (!en || bus_stop || addr_match) |=> !pend);

    // R3: only the host can raise the request
    a_r3_nack_host_only: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(host_set));

    // R3: a completed refusal removes the request
    a_r3_nack_one_shot: assert property (@(posedge clk) disable iff (rst)
        nack_done |=> !pend);

endmodule

// File: rtl/i2ct_status.sv
module i2ct_status
    import i2ct_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  host_addr_clr,
    input  logic  host_rx_rd,
    input  logic  host_tx_wr,
    input  byte_t host_tx_byte,
    input  logic  ev_match,
    input  logic  ev_rx,
    input  byte_t ev_rx_byte,
    input  logic  ev_load,
    output byte_t rx_byte,
    output logic  addr_hit,
    output logic  rx_full,
    output logic  tx_empty,
    output byte_t tx_buf,
    output logic  tx_valid
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rx_byte  <= '0;
            addr_hit <= 1'b0;
            rx_full  <= 1'b0;
            tx_empty <= 1'b0;
            tx_buf   <= '0;
            tx_valid <= 1'b0;
        end else begin
            if (ev_match) begin
                addr_hit <= 1'b1;
            end else if (host_addr_clr) begin
                addr_hit <= 1'b0;
            end

            if (ev_rx) begin
                rx_byte <= ev_rx_byte;
                rx_full <= 1'b1;
            end else if (host_rx_rd) begin
                rx_full <= 1'b0;
            end

            if (host_tx_wr) begin
                tx_buf   <= host_tx_byte;
                tx_valid <= 1'b1;
                tx_empty <= 1'b0;
            end else if (ev_load) begin
                tx_valid <= 1'b0;
                tx_empty <= 1'b1;
            end
        end
    end

    // R12: a finished byte always leaves the full flag set
    a_r12_rx_full_set: assert property (@(posedge clk) disable iff (rst)
        (en && ev_rx) |=> rx_full);

    // R10: a buffer load by the host always clears the empty flag
    a_r10_tx_wr_clears: assert property (@(posedge clk) disable iff (rst)
        (en && host_tx_wr) |=> (!tx_empty && tx_valid));

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  addr_t    own_addr,
    input  line_ev_t ev,
    input  logic     nack_pend,
    input  byte_t    tx_buf,
    input  logic     tx_valid,
    output logic     sda_oe,
    output logic     busy,
    output logic     read_dir,
    output logic     ev_match,
    output logic     ev_rx,
    output byte_t    rx_data,
    output logic     ev_load,
    output logic     nack_done
);

    eng_state_e state;
    bitcnt_t    cnt;
    byte_t      sh;
    logic       m_ack;
    logic       refused;
    byte_t      load_val;
    logic       byte_done;

    assign load_val  = tx_valid ? tx_buf : '1;
    assign byte_done = ev.fall && (cnt == full_count());
    assign rx_data   = sh;

    always_comb begin
        ev_match  = en && (state == ST_ADDR) && byte_done && addr_is_ours(sh, own_addr);
        ev_rx     = en && (state == ST_RX) && byte_done;
        ev_load   = en && ev.fall &&
                    (((state == ST_AACK) && read_dir) || ((state == ST_TACK) && m_ack));
        nack_done = en && (state == ST_RACK) && ev.fall && refused;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            busy     <= 1'b0;
            read_dir <= 1'b0;
            sda_oe   <= 1'b0;
            m_ack    <= 1'b0;
            refused  <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            busy   <= 1'b1;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            busy   <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX: begin
                    if (ev.rise && (cnt < full_count())) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        if (state == ST_ADDR) begin
                            if (addr_is_ours(sh, own_addr)) begin
                                sda_oe   <= 1'b1;
                                read_dir <= sh[0];
                                state    <= ST_AACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else begin
                            sda_oe  <= !nack_pend;
                            refused <= nack_pend;
                            state   <= ST_RACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (read_dir) begin
                            sh     <= load_val;
                            sda_oe <= !load_val[BYTE_W-1];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.fall) begin
                        sda_oe  <= 1'b0;
                        refused <= 1'b0;
                        cnt     <= '0;
                        state   <= ST_RX;
                    end
                end
                ST_TX: begin
                    if (ev.rise && (cnt < full_count())) begin
                        cnt <= cnt + 1'b1;
                    end else if (ev.fall) begin
                        if (cnt == full_count()) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TACK;
                        end else begin
                            sh     <= {sh[BYTE_W-2:0], 1'b1};
                            sda_oe <= !sh[BYTE_W-2];
                        end
                    end
                end
                ST_TACK: begin
                    if (ev.rise) begin
                        m_ack <= !ev.sda;
                    end else if (ev.fall) begin
                        if (m_ack) begin
                            cnt    <= '0;
                            sh     <= load_val;
                            sda_oe <= !load_val[BYTE_W-1];
                            state  <= ST_TX;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: the SDA driver only moves while SCL is low
    a_r8_drive_only_scl_low: assert property (@(posedge clk) disable iff (rst)
        ((sda_oe != $past(sda_oe)) && $past(en)) |-> !ev.scl);

    // R6: busy survives everything except STOP and disable
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && en && !ev.stop) |=> busy);

    // R1: no pending reject means the ninth clock is pulled low
    a_r1_ack_driven: assert property (@(posedge clk) disable iff (rst)
        (ev_rx && !nack_pend) |=> sda_oe);

    // R2: a pending reject leaves the ninth clock released
    a_r2_nack_released: assert property (@(posedge clk) disable iff (rst)
        (ev_rx && nack_pend) |=> !sda_oe);

    // R9 / R11: while ignoring the bus, SDA is never pulled
    a_r11_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_oe);

endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
    import i2ct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [6:0] own_addr,
    input  logic       nack_set,
    input  logic       addr_clr,
    input  logic       rx_rd,
    input  logic       tx_wr,
    input  logic [7:0] tx_byte,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low,
    output logic [7:0] rx_byte,
    output logic       addr_hit,
    output logic       rx_full,
    output logic       tx_empty,
    output logic       busy,
    output logic       nack_pend,
    output logic       read_dir
);

    line_ev_t ev;
    logic     ev_match;
    logic     ev_rx;
    logic     ev_load;
    logic     nack_done;
    byte_t    rx_data;
    byte_t    tx_buf;
    logic     tx_valid;

    i2ct_line_events u_lines (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2ct_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .own_addr  (own_addr),
        .ev        (ev),
        .nack_pend (nack_pend),
        .tx_buf    (tx_buf),
        .tx_valid  (tx_valid),
        .sda_oe    (sda_drive_low),
        .busy      (busy),
        .read_dir  (read_dir),
        .ev_match  (ev_match),
        .ev_rx     (ev_rx),
        .rx_data   (rx_data),
        .ev_load   (ev_load),
        .nack_done (nack_done)
    );

    i2ct_nack_req u_nack (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .host_set   (nack_set),
        .bus_stop   (ev.stop),
        .addr_match (ev_match),
        .nack_done  (nack_done),
        .pend       (nack_pend)
    );

    i2ct_status u_status (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .host_addr_clr (addr_clr),
        .host_rx_rd    (rx_rd),
        .host_tx_wr    (tx_wr),
        .host_tx_byte  (tx_byte),
        .ev_match      (ev_match),
        .ev_rx         (ev_rx),
        .ev_rx_byte    (rx_data),
        .ev_load       (ev_load),
        .rx_byte       (rx_byte),
        .addr_hit      (addr_hit),
        .rx_full       (rx_full),
        .tx_empty      (tx_empty),
        .tx_buf        (tx_buf),
        .tx_valid      (tx_valid)
    );

    // R7: one cycle of disable leaves everything idle and released
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && !sda_drive_low && !addr_hit && !rx_full &&
                 !tx_empty && !nack_pend));

endmodule

// File: tb/sim_i2ct_target.sv
module sim_i2ct_target;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, en, nack_set, addr_clr, rx_rd, tx_wr;
    logic [6:0] own_addr;
    logic [7:0] tx_byte;
    logic       scl, sda_m, bus_sda;
    logic       sda_drive_low, addr_hit, rx_full, tx_empty, busy, nack_pend, read_dir;
    logic [7:0] rx_byte;

    assign bus_sda = sda_m & ~sda_drive_low;

    i2ct_target u0 (
        .clk(clk), .rst(rst), .en(en), .own_addr(own_addr), .nack_set(nack_set),
        .addr_clr(addr_clr), .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .scl_i(scl), .sda_i(bus_sda), .sda_drive_low(sda_drive_low), .rx_byte(rx_byte),
        .addr_hit(addr_hit), .rx_full(rx_full), .tx_empty(tx_empty), .busy(busy),
        .nack_pend(nack_pend), .read_dir(read_dir)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    int  r8_bad = 0;
    bit  done   = 0;
    logic oe_seen = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8 monitor: driver changes observed with SCL high
    always @(posedge clk) begin
        #1;
        if (!rst && en && scl && (sda_drive_low != oe_seen)) r8_bad++;
        oe_seen = sda_drive_low;
    end

    task automatic q();
        repeat (4) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl = 1'b1; q();
        sda_m = 1'b0; q();
        scl = 1'b0; q();
    endtask

    task automatic m_rstart();
        sda_m = 1'b1; q();
        scl = 1'b1; q();
        sda_m = 1'b0; q();
        scl = 1'b0; q();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; q();
        scl = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    task automatic m_clock(input logic b, output logic s);
        sda_m = b; q();
        scl = 1'b1; q();
        s = bus_sda;
        scl = 1'b0; q();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_clock(b[i], s);
        m_clock(1'b1, s);
        ack = !s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_clock(1'b1, s);
            d = {d[6:0], s};
        end
        m_clock(!mack, s);
    endtask

    task automatic pulse_nack();
        nack_set = 1'b1; @(negedge clk); nack_set = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_aclr();
        addr_clr = 1'b1; @(negedge clk); addr_clr = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_rd();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
    endtask

    task automatic load_tx(input logic [7:0] v);
        tx_byte = v; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        logic [7:0] prev;
        rst = 1'b1; en = 1'b1; own_addr = 7'h2A; nack_set = 0; addr_clr = 0;
        rx_rd = 0; tx_wr = 0; tx_byte = 8'h00; scl = 1'b1; sda_m = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7 reset state
        chk("R7 reset busy", busy, 0);
        chk("R7 reset addr_hit", addr_hit, 0);
        chk("R7 reset rx_full", rx_full, 0);
        chk("R7 reset tx_empty", tx_empty, 0);
        chk("R7 reset sda", sda_drive_low, 0);
        chk("R7 reset nack_pend", nack_pend, 0);

        // R5 / R9: sweep of all addresses in write direction
        for (int a = 0; a < 128; a++) begin
            m_start();
            if (a == 0) chk("R6 busy after START", busy, 1);
            write_byte({a[6:0], 1'b0}, ack);
            chk("R5 R9 address ack", ack, (a == 'h2A) ? 1 : 0);
            write_byte(8'h5A, ack);
            if (a == 'h2A) begin
                chk("R5 addr_hit", addr_hit, 1);
                chk("R5 read_dir write", read_dir, 0);
                chk("R1 data ack", ack, 1);
                chk("R12 rx byte", rx_byte, 'h5A);
                pulse_aclr();
                pulse_rd();
            end else begin
                chk("R9 data not acked", ack, 0);
                chk("R9 no rx_full", rx_full, 0);
                chk("R9 no addr_hit", addr_hit, 0);
            end
            m_stop();
        end
        chk("R6 busy after STOP", busy, 0);

        // R1 / R12: data sweep in write direction
        m_start();
        write_byte(8'h54, ack);
        chk("R5 addr_hit set", addr_hit, 1);
        pulse_aclr();
        chk("R5 addr_clr", addr_hit, 0);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] v;
            v = 8'((k * 37 + 5) ^ (k << 4));
            write_byte(v, ack);
            chk("R1 ack", ack, 1);
            chk("R12 rx_byte", rx_byte, v);
            chk("R12 rx_full set", rx_full, 1);
            pulse_rd();
            chk("R12 rx_rd clears", rx_full, 0);
        end

        // R2 / R3: one-shot refusal
        pulse_nack();
        chk("R3 nack_pend set", nack_pend, 1);
        write_byte(8'hC3, ack);
        chk("R2 NACK given", ack, 0);
        chk("R2 byte still received", rx_byte, 'hC3);
        chk("R3 cleared after NACK", nack_pend, 0);
        pulse_rd();
        write_byte(8'h3C, ack);
        chk("R3 next byte acked", ack, 1);
        pulse_rd();

        // R4: STOP clears
        pulse_nack();
        m_stop();
        chk("R4 STOP clears", nack_pend, 0);
        chk("R6 busy off", busy, 0);

        // R4: address match clears
        m_start();
        pulse_nack();
        write_byte(8'h54, ack);
        chk("R4 address still acked", ack, 1);
        chk("R4 match clears", nack_pend, 0);
        pulse_aclr();

        // R4: disable clears
        pulse_nack();
        en = 1'b0; @(negedge clk);
        chk("R4 disable clears", nack_pend, 0);
        pulse_nack();
        chk("R3 ignored while disabled", nack_pend, 0);
        en = 1'b1; @(negedge clk);
        m_stop();

        // R5 / R6 / R10 / R11: pointer write then repeated START read
        load_tx(8'h96);
        chk("R10 tx_wr clears empty", tx_empty, 0);
        m_start();
        write_byte(8'h54, ack);
        pulse_aclr();
        write_byte(8'h07, ack);
        chk("R1 pointer acked", ack, 1);
        m_rstart();
        chk("R6 busy across repeated START", busy, 1);
        write_byte(8'h55, ack);
        chk("R5 read address acked", ack, 1);
        chk("R5 addr_hit again", addr_hit, 1);
        chk("R5 read_dir", read_dir, 1);
        chk("R10 empty after address", tx_empty, 1);
        prev = 8'h96;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            v = 8'(k * 8'h23 + 8'h11);
            load_tx(v);
            chk("R10 empty cleared", tx_empty, 0);
            read_byte(1'b1, d);
            chk("R10 read data", d, prev);
            chk("R10 empty after ack", tx_empty, 1);
            prev = v;
        end
        read_byte(1'b1, d);
        chk("R10 last loaded", d, prev);
        read_byte(1'b0, d);
        chk("R10 unloaded gives FF", d, 'hFF);
        load_tx(8'h00);
        read_byte(1'b1, d);
        chk("R11 silent after controller NACK", d, 'hFF);
        chk("R11 buffer untouched", tx_empty, 0);
        m_stop();
        chk("R6 busy off after read", busy, 0);

        // R7: disable while pulling the address ACK
        m_start();
        for (int i = 7; i >= 0; i--) begin
            logic s;
            m_clock(((8'h54 >> i) & 1) != 0, s);
        end
        chk("R1 ack being driven", sda_drive_low, 1);
        chk("R5 hit before disable", addr_hit, 1);
        en = 1'b0; @(negedge clk);
        chk("R7 sda released", sda_drive_low, 0);
        chk("R7 busy cleared", busy, 0);
        chk("R7 addr_hit cleared", addr_hit, 0);
        chk("R7 tx_empty cleared", tx_empty, 0);
        en = 1'b1; @(negedge clk);
        m_stop();

        chk("R8 driver changes only with SCL low", r8_bad, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule